// File: doc/BRIEF.md
# Bus Initiator Termination Handler

This block sits on the initiator side of one port of a PCI-to-PCI bridge. Each time the bridge starts a transaction on a target bus, the block watches that bus and decides how the transaction ends. There are five possible endings:

- **Normal completion.**
- **Master abort.** No target claimed the cycle in time.
- **Special-cycle abort.** A master abort on a special cycle is the expected ending, so it is reported separately.
- **Latency-timer cut-off, resumed.** A posted write that was cut off is resumed at the next DWORD.
- **Latency-timer cut-off, not resumed.** A prefetching read or a delayed write that was cut off is not restarted.

The block also does the following:

- It keeps one sticky received-master-abort status bit for each bus side.
- It produces a one-clock, active-low system-error pulse when a posted write is master-aborted and the configuration allows it.
- It tags delayed-transaction queue entries that were aborted. When the original initiator retries a tagged entry, the block tells the port to withhold DEVSEL#, and then it frees the tag.

Transactions enter the block on a valid/ready request stream. The request stream is accepted only while the block is idle, so `req_ready` doubles as the block's busy indication. The outcome leaves on a valid/ready result stream. The result is held stable until `res_ready` is seen. No new request is accepted until the result has been taken, so back-pressure on the result stream stalls the request stream.

The bus observation inputs, the configuration bits, the status outputs, the error pulse and the retry lookup are plain signals with no handshake.

Top module: `bus_init_term`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the result has been taken. `res_valid` with `res_code`, `res_addr` and `res_left` stays high and unchanged until an edge where `res_ready` is high.
- R2: Cycle n is the n-th clock after acceptance. If `bus_devsel` is high in none of cycles 1 to 5, the result is issued on the edge that ends cycle 5 as a master abort. In that case `res_addr` equals the request address and `res_left` equals the request length. A `bus_devsel` in any of cycles 1 to 5 cancels the abort.
- R3: `sta_rma[0]` (primary) and `sta_rma[1]` (secondary) are set by a master abort on the bus given by `req_bus`, except on special cycles. The bits are sticky. They clear only when the matching `sta_clr` bit is high, and a set in the same cycle wins over the clear.
- R4: Requests use the kind encoding 0 = posted write, 1 = delayed read, 2 = delayed write, 3 = special cycle. A posted write that is master-aborted ends with `res_code` 1, and its data is discarded.
- R5: A delayed read or delayed write that is master-aborted ends with `res_code` 2 and tags queue entry `req_qidx`. While `rty_valid` is high, `rty_refuse` equals the tag of entry `rty_idx`. A retry that sees the tag clears that tag on the same edge.
- R6: `serr_n` goes low for exactly one cycle, in the cycle in which the result appears. This happens only for a posted-write master abort where all three of the following hold: `cfg_ma_mode` is 1, `cfg_serr_en[req_sport]` is 1, and `cfg_ma_pw_dis` is 0.
- R7: A master abort on a special cycle ends with `res_code` 3. It sets no status bit and produces no `serr_n` pulse.
- R8: Once claimed, each cycle with `bus_xfer` high moves one DWORD. The transfer of the last DWORD ends the transaction with `res_code` 0, `res_left` 0, and `res_addr` equal to the request address plus 4 times the length.
- R9: Suppose `bus_lt_exp` and `bus_gnt_lost` are both high in a claimed cycle on a posted write. The transaction then ends with `res_code` 4. `res_addr` is the request address plus 4 times the DWORDs moved, counting the current cycle, and `res_left` is the remaining count.
- R10: The same latency-timer cut-off on a delayed read or delayed write ends with `res_code` 5 and is not resumed. `res_left` reports the DWORDs that were not fetched.
- R11: The latency-timer cut-off is ignored when `req_mwi` was set on the request, or when `bus_gnt_lost` is low.
- R12: If the last DWORD moves in the same cycle as a latency-timer cut-off, the transaction ends as a completion with `res_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_kind | input | 2 | 0 posted write, 1 delayed read, 2 delayed write, 3 special cycle |
| req_bus | input | 1 | Target bus side: 0 primary, 1 secondary |
| req_sport | input | 1 | Which secondary port's SERR enable applies |
| req_mwi | input | 1 | Request is a Memory Write and Invalidate burst |
| req_qidx | input | QW | Delayed-queue entry of the request |
| req_addr | input | AW | Start byte address |
| req_len | input | CW | Length in DWORDs (at least 1) |
| bus_devsel | input | 1 | Target claim seen this cycle |
| bus_xfer | input | 1 | A data phase completed this cycle |
| bus_lt_exp | input | 1 | Latency timer expired |
| bus_gnt_lost | input | 1 | Bus grant removed |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_code | output | 3 | Ending code (see R4, R5, R7 to R10) |
| res_addr | output | AW | Address of the next DWORD not delivered |
| res_left | output | CW | DWORDs not delivered |
| cfg_ma_mode | input | 1 | Master-abort reporting mode |
| cfg_serr_en | input | 2 | SERR enable per secondary port |
| cfg_ma_pw_dis | input | 1 | Suppress SERR on posted-write master abort |
| sta_rma | output | 2 | Sticky received-master-abort bits |
| sta_clr | input | 2 | Write-one-to-clear strobes |
| serr_n | output | 1 | Active-low system-error pulse |
| rty_valid | input | 1 | Initiator retrying a delayed entry |
| rty_idx | input | QW | Entry being retried |
| rty_refuse | output | 1 | Withhold DEVSEL# for this retry |

## Verification
Two endings can fall in the same clock: the last data phase of a burst and a latency-timer cut-off. The sweep provokes this by stepping the cut-off cycle across every data phase of bursts of one to three DWORDs, including the final one. It expects a completion when the cut-off lands on the last DWORD, and a resume or stop with the exact address and remaining count otherwise. A second collision is a target claim arriving on the fifth clock, which is the last cycle before the abort would be declared. The sweep moves the claim cycle from 1 to 6 and judges the result against the claim window.

// File: rtl/bit_pkg.sv
package bit_pkg;
  typedef enum logic [1:0] {
    K_PW  = 2'd0,
    K_DR  = 2'd1,
    K_DW  = 2'd2,
    K_SPC = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    C_DONE      = 3'd0,
    C_MA_DROP   = 3'd1,
    C_MA_DLY    = 3'd2,
    C_MA_SPC    = 3'd3,
    C_LT_RESUME = 3'd4,
    C_LT_STOP   = 3'd5
  } code_e;
endpackage

// File: rtl/bit_dsel_timer.sv
module bit_dsel_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic devsel,
  output logic claimed,
  output logic abort
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;
  logic          hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (start) begin
      cnt <= TW'(1);
      hit <= 1'b0;
    end else if (run) begin
      if (devsel) hit <= 1'b1;
      if (cnt != TW'(LIMIT)) cnt <= cnt + TW'(1);
    end
  end

  assign claimed = run & (hit | devsel);
  assign abort   = run & ~hit & ~devsel & (cnt == TW'(LIMIT));
endmodule

// File: rtl/bit_judge.sv
module bit_judge
  import bit_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  kind_e         kind,
  input  logic          mwi,
  input  logic [CW-1:0] len,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] done,
  input  logic          claimed,
  input  logic          xfer,
  input  logic          lt_exp,
  input  logic          gnt_lost,
  input  logic          abort,
  output logic [CW-1:0] done_nx,
  output logic          fin,
  output code_e         code,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] rleft
);
  logic last, lt_hit;

  always_comb begin
    done_nx = done + CW'(claimed & xfer);
    last    = claimed & xfer & (done_nx == len);
    lt_hit  = claimed & lt_exp & gnt_lost & ~mwi;
    raddr   = addr + (AW'(done_nx) << 2);
    rleft   = len - done_nx;
    fin     = 1'b1;
    code    = C_DONE;
    if (abort) begin
      unique case (kind)
        K_PW:    code = C_MA_DROP;
        K_SPC:   code = C_MA_SPC;
        default: code = C_MA_DLY;
      endcase
    end else if (last) begin
      code = C_DONE;
    end else if (lt_hit) begin
      code = (kind == K_PW) ? C_LT_RESUME : C_LT_STOP;
    end else begin
      fin = 1'b0;
    end
  end
endmodule

// File: rtl/bit_stat.sv
module bit_stat
  import bit_pkg::*;
#(
  parameter int NQ = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  code_e         ev_code,
  input  logic          ev_bus,
  input  logic          ev_sport,
  input  logic [QW-1:0] ev_qidx,
  input  logic          cfg_ma_mode,
  input  logic [1:0]    cfg_serr_en,
  input  logic          cfg_ma_pw_dis,
  input  logic [1:0]    sta_clr,
  output logic [1:0]    sta_rma,
  output logic          serr_n,
  input  logic          rty_valid,
  input  logic [QW-1:0] rty_idx,
  output logic          rty_refuse
);
  logic          ma_cnt;
  logic [NQ-1:0] tag;

  assign ma_cnt = ev & (ev_code == C_MA_DROP || ev_code == C_MA_DLY);

  for (genvar b = 0; b < 2; b++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rst_n) sta_rma[b] <= 1'b0;
      else        sta_rma[b] <= (sta_rma[b] & ~sta_clr[b]) | (ma_cnt & (ev_bus == b[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serr_n <= 1'b1;
    else        serr_n <= ~(ev & (ev_code == C_MA_DROP) & cfg_ma_mode &
                            cfg_serr_en[ev_sport] & ~cfg_ma_pw_dis);
  end

  for (genvar i = 0; i < NQ; i++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rst_n)
        tag[i] <= 1'b0;
      else if (ev && ev_code == C_MA_DLY && ev_qidx == QW'(i))
        tag[i] <= 1'b1;
      else if (rty_valid && rty_idx == QW'(i))
        tag[i] <= 1'b0;
    end
  end

  assign rty_refuse = rty_valid & tag[rty_idx];
endmodule

// File: rtl/bus_init_term.sv
module bus_init_term
  import bit_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int NQ    = 4,
  parameter int LIMIT = 5,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_bus,
  input  logic          req_sport,
  input  logic          req_mwi,
  input  logic [QW-1:0] req_qidx,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_len,
  input  logic          bus_devsel,
  input  logic          bus_xfer,
  input  logic          bus_lt_exp,
  input  logic          bus_gnt_lost,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [2:0]    res_code,
  output logic [AW-1:0] res_addr,
  output logic [CW-1:0] res_left,
  input  logic          cfg_ma_mode,
  input  logic [1:0]    cfg_serr_en,
  input  logic          cfg_ma_pw_dis,
  output logic [1:0]    sta_rma,
  input  logic [1:0]    sta_clr,
  output logic          serr_n,
  input  logic          rty_valid,
  input  logic [QW-1:0] rty_idx,
  output logic          rty_refuse
);
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_RPT} st_e;

  st_e           st;
  kind_e         kind_q;
  logic          bus_q, sport_q, mwi_q;
  logic [QW-1:0] qidx_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] len_q, done_q, done_nx, rleft;
  logic [AW-1:0] raddr;
  logic          accept, run, claimed, abort, fin;
  code_e         code;

  assign accept    = req_valid & (st == S_IDLE);
  assign run       = (st == S_ACT);
  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_RPT);

  bit_dsel_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(run),
    .devsel(bus_devsel), .claimed(claimed), .abort(abort)
  );

  bit_judge #(.AW(AW), .CW(CW)) u_judge (
    .kind(kind_q), .mwi(mwi_q), .len(len_q), .addr(addr_q), .done(done_q),
    .claimed(claimed), .xfer(bus_xfer), .lt_exp(bus_lt_exp),
    .gnt_lost(bus_gnt_lost), .abort(abort), .done_nx(done_nx), .fin(fin),
    .code(code), .raddr(raddr), .rleft(rleft)
  );

  bit_stat #(.NQ(NQ)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev(run & fin), .ev_code(code),
    .ev_bus(bus_q), .ev_sport(sport_q), .ev_qidx(qidx_q),
    .cfg_ma_mode(cfg_ma_mode), .cfg_serr_en(cfg_serr_en),
    .cfg_ma_pw_dis(cfg_ma_pw_dis), .sta_clr(sta_clr), .sta_rma(sta_rma),
    .serr_n(serr_n), .rty_valid(rty_valid), .rty_idx(rty_idx),
    .rty_refuse(rty_refuse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= K_PW;
      bus_q    <= 1'b0;
      sport_q  <= 1'b0;
      mwi_q    <= 1'b0;
      qidx_q   <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      done_q   <= '0;
      res_code <= '0;
      res_addr <= '0;
      res_left <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st      <= S_ACT;
          kind_q  <= kind_e'(req_kind);
          bus_q   <= req_bus;
          sport_q <= req_sport;
          mwi_q   <= req_mwi;
          qidx_q  <= req_qidx;
          addr_q  <= req_addr;
          len_q   <= req_len;
          done_q  <= '0;
        end
        S_ACT: begin
          done_q <= done_nx;
          if (fin) begin
            st       <= S_RPT;
            res_code <= 3'(code);
            res_addr <= raddr;
            res_left <= rleft;
          end
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_init_term_chk.sv
module bus_init_term_chk #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          res_ready,
  input logic [2:0]    res_code,
  input logic [AW-1:0] res_addr,
  input logic [CW-1:0] res_left,
  input logic [1:0]    sta_rma,
  input logic [1:0]    sta_clr,
  input logic          serr_n
);
  // R1: result held until taken
  a_r1_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) &&
                                $stable(res_addr) && $stable(res_left));

  // R3: status bits fall only after a clear strobe
  a_r3_sticky_pri: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sta_rma[0]) |-> $past(sta_clr[0]));
  a_r3_sticky_sec: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sta_rma[1]) |-> $past(sta_clr[1]));

  // R6: error pulse lasts one cycle and only accompanies a posted-write abort
  a_r6_serr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |=> serr_n);
  a_r6_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serr_n) |-> res_valid && res_code == 3'd1);

  // R7: special-cycle abort leaves status untouched
  a_r7_spc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && res_code == 3'd3 && sta_clr == 2'b00 |-> $stable(sta_rma));
endmodule

bind bus_init_term bus_init_term_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_code(res_code), .res_addr(res_addr), .res_left(res_left),
  .sta_rma(sta_rma), .sta_clr(sta_clr), .serr_n(serr_n)
);

// File: tb/bus_init_term_tb.sv
`timescale 1ns/1ps
module bus_init_term_tb;
  localparam int AW = 32, CW = 8, NQ = 4, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_bus = 0, req_sport = 0, req_mwi = 0;
  logic [1:0] req_kind = 0;
  logic [QW-1:0] req_qidx = 0;
  logic [AW-1:0] req_addr = 0;
  logic [CW-1:0] req_len = 1;
  logic bus_devsel = 0, bus_xfer = 0, bus_lt_exp = 0, bus_gnt_lost = 0;
  logic res_ready = 0, cfg_ma_mode = 0, cfg_ma_pw_dis = 0, rty_valid = 0;
  logic [1:0] cfg_serr_en = 0, sta_clr = 0;
  logic [QW-1:0] rty_idx = 0;
  logic req_ready, res_valid, serr_n, rty_refuse;
  logic [2:0] res_code;
  logic [AW-1:0] res_addr;
  logic [CW-1:0] res_left;
  logic [1:0] sta_rma;

  int checks = 0, errors = 0, seq = 0;

  always #4 clk = ~clk;

  bus_init_term #(.AW(AW), .CW(CW), .NQ(NQ)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind, claim cycle d (0 = never), len, cut-off cycle lt (0 = none), grant removed, mwi
  task automatic txn(input int kind, input int d, input int len, input int lt,
                     input bit gl, input bit mwi);
    bit mam, dis, bus, sp, claimed, ltv, ab, exp_serr;
    bit [1:0] en;
    int ec, ecode, done, c, q;
    logic [AW-1:0] base, eaddr;
    mam = seq[0]; en = seq[2:1]; dis = seq[3]; sp = seq[4]; bus = seq[5];
    q = seq % NQ;
    base = 32'h1000_0000 + 32'(seq * 64);
    seq++;
    claimed = (d >= 1 && d <= 5);
    ab = !claimed;
    if (ab) begin
      ec = 5; done = 0;
      ecode = (kind == 0) ? 1 : (kind == 3) ? 3 : 2;
    end else begin
      ltv = (lt >= d) && (lt < d + len - 1) && gl && !mwi;
      if (ltv) begin ec = lt; done = lt - d + 1; ecode = (kind == 0) ? 4 : 5; end
      else begin ec = d + len - 1; done = len; ecode = 0; end
    end
    eaddr = base + 32'(4 * done);
    exp_serr = ab && kind == 0 && mam && en[sp] && !dis;

    @(negedge clk);
    cfg_ma_mode = mam; cfg_serr_en = en; cfg_ma_pw_dis = dis;
    req_kind = 2'(kind); req_bus = bus; req_sport = sp; req_mwi = mwi;
    req_qidx = QW'(q); req_addr = base; req_len = CW'(len); req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R1 busy after accept", req_ready, 0);
    c = 1;
    while (1) begin
      bus_devsel = (c == d);
      bus_xfer   = claimed && (c >= d);
      bus_lt_exp = (c == lt);
      bus_gnt_lost = (c == lt) && gl;
      @(posedge clk);
      @(negedge clk);
      if (res_valid || c > 30) break;
      c++;
    end
    bus_devsel = 0; bus_xfer = 0; bus_lt_exp = 0; bus_gnt_lost = 0;
    chk(c == ec, ab ? "R2 abort cycle" : "R8/R9/R12 end cycle", c, ec);
    chk(res_code == 3'(ecode),
        ab ? (kind == 0 ? "R4 code" : kind == 3 ? "R7 code" : "R5 code")
           : (ecode == 0 ? "R8/R11/R12 code" : ecode == 4 ? "R9 code" : "R10 code"),
        res_code, ecode);
    chk(res_addr == eaddr, ab ? "R2 addr" : "R9 resume addr", res_addr, eaddr);
    chk(res_left == CW'(len - done), ab ? "R2 left" : "R9/R10 left", res_left, len - done);
    chk(serr_n == !exp_serr, "R6 serr", serr_n, !exp_serr);
    chk(sta_rma == ((ab && kind != 3) ? (bus ? 2'b10 : 2'b01) : 2'b00),
        kind == 3 ? "R7 status" : "R3 status", sta_rma, 0);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid && res_code == 3'(ecode), "R1 hold", res_code, ecode);
    res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 0;
    chk(serr_n == 1 && req_ready == 1, "R6/R1 after take", {serr_n, req_ready}, 3);
    rty_valid = 1; rty_idx = QW'(q);
    #1;
    chk(rty_refuse == (ab && (kind == 1 || kind == 2)), "R5 refuse", rty_refuse,
        ab && (kind == 1 || kind == 2));
    @(posedge clk);
    @(negedge clk);
    chk(rty_refuse == 0, "R5 entry removed", rty_refuse, 0);
    rty_valid = 0;
    sta_clr = 2'b11;
    @(posedge clk);
    @(negedge clk);
    sta_clr = 2'b00;
    chk(sta_rma == 2'b00, "R3 clear", sta_rma, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(req_ready == 1 && res_valid == 0 && serr_n == 1 && sta_rma == 0,
        "R1 reset state", {req_ready, res_valid, serr_n, sta_rma}, 5'b10100);
    // near-exhaustive sweep
    for (int k = 0; k < 4; k++)
      for (int d = 0; d <= 6; d++)
        for (int len = 1; len <= 3; len++)
          for (int lt = 0; lt <= 4; lt++)
            for (int m = 0; m < 2; m++)
              txn(k, d, len, lt, 1'b1, m[0]);
    // R11: cut-off without grant removal is ignored
    for (int k = 0; k < 3; k++)
      for (int lt = 1; lt <= 3; lt++)
        txn(k, 1, 4, lt, 1'b0, 1'b0);
    // R6: all configuration combinations on posted-write aborts
    for (int i = 0; i < 32; i++) txn(0, 0, 2, 0, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule